// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt requests from six sources (two external pins, three timers and a serial port), holds a request flag for each, and decides which one a CPU core should service next. Each source can be enabled individually and placed at a high or a low level. A high-level request may interrupt a low-level handler. Requests at the same level wait until the running handler returns. A global enable masks everything, and a bypass bit drops the level scheme so that the enable register alone decides acceptance.

The CPU sees a request line and a vector address. It answers with a one-cycle acknowledge when it enters the handler and a one-cycle return pulse when it leaves. The external pins are sampled once per machine cycle, on a strobe from the clock generator. Each pin works either as a level-sensitive request (active low) or as a falling-edge request. The block also drives the wake signal for the power-saving modes. In one setting, a newly raised flag from any source wakes the core, even from a masked source. In the other setting, only an acceptable request keeps the wake line high.

Top module: `irqc_top`

## Requirements
- R1: After reset the request line and wake are low, all flags read 0, and the enable and level registers both read 0x40.
- R2: Register map on `reg_addr`. Address 0 is enable: bit 7 global, bits 5:0 per source. Address 1 is level: bit 7 bypass, bits 5:0 high-level per source. Address 2 is control: bit 0 ext0 edge mode, bit 1 ext1 edge mode, bit 2 wake-select. Address 3 is flags, bits 5:0. Source bit order is ext0, timer0, ext1, timer1, serial, timer2. Bit 6 of addresses 0 and 1 always reads 1.
- R3: The vector presented for source index i is 8*i+3, so the vectors are 0x03, 0x0B, 0x13, 0x1B, 0x23 and 0x2B.
- R4: With the global enable at 0, no request is presented, whatever the flags and per-source enables.
- R5: Among several pending requests at one level, the lowest source index is presented first.
- R6: A high-level request is presented during a low-level handler. A request at the level of a running handler waits for the return pulse. Each return pulse closes the innermost open level.
- R7: With bypass at 1, the level bits are ignored: order follows R5 only, and no request is presented while any handler is open.
- R8: In edge mode, a pin sampled high and then low on the next machine-cycle strobe sets its flag once. Holding the pin low sets nothing more. Software may set or clear the flag through address 3.
- R9: In level mode, the external flag equals the inverse of the last sampled pin value, and software writes to it are ignored.
- R10: Acknowledge clears the flag of the served source for ext0, timer0, ext1 and timer1. The serial and timer2 flags stay set until software clears them.
- R11: A hardware event on a source takes precedence over an acknowledge clear or a software write to its flag in the same cycle.
- R12: With wake-select at 1, wake pulses for one cycle after any flag goes from 0 to 1, enabled or not.
- R13: With wake-select at 0, wake is high only while some enabled flag is set and the global enable is 1.
- R14: The cycle after an accepted acknowledge, the request line is low. It is then recomputed from the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_tick | input | 1 | Machine-cycle strobe that samples the external pins |
| ext_pin | input | 2 | External request pins, active low |
| src_evt | input | 4 | One-cycle events: bit 0 timer0, bit 1 timer1, bit 2 serial, bit 3 timer2 |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 16 | Vector address of the presented request |
| irq_ack | input | 1 | CPU enters the presented handler |
| irq_reti | input | 1 | CPU returns from a handler |
| wake | output | 1 | Wake-up for idle and power-down |

## Verification
The sharpest collisions are a flag being set by hardware in the same cycle that it is cleared. One case is a timer event arriving with the acknowledge of that same timer. The other is a serial event arriving with a software write of zero to the flags register. The bench drives both inputs on one clock edge, then reads the flags register back. The flag must still be 1, and the source must be presented again after the return pulse. A second collision is a high-level request arriving while a low-level handler is open. The bench checks that the high request is presented, and that the deferred low request appears only after two return pulses.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC      = 6;
    localparam int NEXT      = 2;
    localparam int NPERI     = 4;
    localparam int IDX_W     = $clog2(NSRC);
    localparam int REG_W     = 8;
    localparam int VEC_BASE  = 3;
    localparam int VEC_STEP  = 8;

    // source index of each external pin and each peripheral event
    localparam int EXT_IDX  [NEXT]  = '{0, 2};
    localparam int PERI_IDX [NPERI] = '{1, 3, 4, 5};

    // sources whose flag is cleared by the acknowledge
    localparam logic [NSRC-1:0] AUTO_CLR = 6'b001111;

    typedef enum logic [1:0] {
        RA_EN  = 2'd0,
        RA_LVL = 2'd1,
        RA_CTL = 2'd2,
        RA_FLG = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             valid;
        logic             hi;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } act_t;

    function automatic logic [IDX_W-1:0] first_one(input logic [NSRC-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    function automatic int vec_of(input logic [IDX_W-1:0] idx);
        return VEC_BASE + VEC_STEP * int'(idx);
    endfunction

endpackage

// File: rtl/irqc_pin_samp.sv
module irqc_pin_samp #(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [NPIN-1:0] pin,
    output logic [NPIN-1:0] low_lvl,
    output logic [NPIN-1:0] fall
);

    logic [NPIN-1:0] samp_q;

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            always_ff @(posedge clk) begin
                if (rst) begin
                    samp_q[p] <= 1'b1;
                end else if (tick) begin
                    samp_q[p] <= pin[p];
                end
            end
            // high in the previous sample, low in this one
            assign fall[p]    = tick & samp_q[p] & ~pin[p];
            assign low_lvl[p] = ~samp_q[p];
        end
    endgenerate

endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NEXT-1:0]  edge_mode,
    input  logic [NEXT-1:0]  ext_fall,
    input  logic [NEXT-1:0]  ext_low,
    input  logic [NPERI-1:0] peri_evt,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             sw_we,
    input  logic [NSRC-1:0]  sw_data,
    output logic [NSRC-1:0]  flag_vis
);

    logic [NSRC-1:0] hw_set;
    logic [NSRC-1:0] sw_ok;
    logic [NSRC-1:0] lvl_sel;
    logic [NSRC-1:0] lvl_val;
    logic [NSRC-1:0] st_q;

    always_comb begin
        hw_set  = '0;
        sw_ok   = '1;
        lvl_sel = '0;
        lvl_val = '0;
        for (int e = 0; e < NEXT; e++) begin
            hw_set[EXT_IDX[e]]  = ext_fall[e] & edge_mode[e];
            sw_ok[EXT_IDX[e]]   = edge_mode[e];
            lvl_sel[EXT_IDX[e]] = ~edge_mode[e];
            lvl_val[EXT_IDX[e]] = ext_low[e];
        end
        for (int p = 0; p < NPERI; p++) begin
            hw_set[PERI_IDX[p]] = peri_evt[p];
        end
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q[i] <= 1'b0;
                end else if (hw_set[i]) begin
                    st_q[i] <= 1'b1;
                end else if (clr_en && clr_idx == IDX_W'(i) && AUTO_CLR[i]) begin
                    st_q[i] <= 1'b0;
                end else if (sw_we && sw_ok[i]) begin
                    st_q[i] <= sw_data[i];
                end
            end
        end
    endgenerate

    assign flag_vis = (st_q & ~lvl_sel) | (lvl_val & lvl_sel);

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] pri,
    input  logic            gie,
    input  logic            bypass,
    input  act_t            act,
    output pick_t           pick
);

    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] hi_set;
    logic [NSRC-1:0] lo_set;

    assign elig   = flags & en & {NSRC{gie}};
    assign hi_set = bypass ? '0   : (elig & pri);
    assign lo_set = bypass ? elig : (elig & ~pri);

    always_comb begin
        pick = '0;
        if (|hi_set && !act.hi) begin
            pick.valid = 1'b1;
            pick.hi    = 1'b1;
            pick.idx   = first_one(hi_set);
        end else if (|lo_set && !act.hi && !act.lo) begin
            pick.valid = 1'b1;
            pick.hi    = 1'b0;
            pick.idx   = first_one(lo_set);
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mc_tick,
    input  logic [NEXT-1:0]  ext_pin,
    input  logic [NPERI-1:0] src_evt,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    input  logic             irq_ack,
    input  logic             irq_reti,
    output logic             wake
);

    logic [NSRC-1:0] en_q, pri_q, flags_d, flag_vis;
    logic            gie_q, byp_q, wsel_q, wake_q;
    logic [NEXT-1:0] typ_q, ext_fall, ext_low;
    act_t            act_q, act_n;
    pick_t           pick, pick_q;
    logic            ack_ok;
    reg_addr_e       ra;
    wire             unused_wbit = reg_wdata[6];

    assign ra     = reg_addr_e'(reg_addr);
    assign ack_ok = irq_ack & pick_q.valid;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            gie_q  <= 1'b0;
            pri_q  <= '0;
            byp_q  <= 1'b0;
            typ_q  <= '0;
            wsel_q <= 1'b0;
        end else if (reg_wr) begin
            case (ra)
                RA_EN: begin
                    en_q  <= reg_wdata[NSRC-1:0];
                    gie_q <= reg_wdata[7];
                end
                RA_LVL: begin
                    pri_q <= reg_wdata[NSRC-1:0];
                    byp_q <= reg_wdata[7];
                end
                RA_CTL: begin
                    typ_q  <= reg_wdata[NEXT-1:0];
                    wsel_q <= reg_wdata[2];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (ra)
            RA_EN:   reg_rdata = {gie_q, 1'b1, en_q};
            RA_LVL:  reg_rdata = {byp_q, 1'b1, pri_q};
            RA_CTL:  reg_rdata = {5'b0, wsel_q, typ_q};
            default: reg_rdata = {2'b0, flag_vis};
        endcase
    end

    irqc_pin_samp #(.NPIN(NEXT)) u_pins (
        .clk     (clk),
        .rst     (rst),
        .tick    (mc_tick),
        .pin     (ext_pin),
        .low_lvl (ext_low),
        .fall    (ext_fall)
    );

    irqc_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .edge_mode (typ_q),
        .ext_fall  (ext_fall),
        .ext_low   (ext_low),
        .peri_evt  (src_evt),
        .clr_en    (ack_ok),
        .clr_idx   (pick_q.idx),
        .sw_we     (reg_wr && ra == RA_FLG),
        .sw_data   (reg_wdata[NSRC-1:0]),
        .flag_vis  (flag_vis)
    );

    irqc_arb u_arb (
        .flags  (flag_vis),
        .en     (en_q),
        .pri    (pri_q),
        .gie    (gie_q),
        .bypass (byp_q),
        .act    (act_q),
        .pick   (pick)
    );

    // active-level tracker: return pops first, acknowledge pushes
    always_comb begin
        act_n = act_q;
        if (irq_reti) begin
            if (act_q.hi) act_n.hi = 1'b0;
            else          act_n.lo = 1'b0;
        end
        if (ack_ok) begin
            if (pick_q.hi) act_n.hi = 1'b1;
            else           act_n.lo = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= '0;
            pick_q  <= '0;
            flags_d <= '0;
            wake_q  <= 1'b0;
        end else begin
            act_q   <= act_n;
            pick_q  <= ack_ok ? '0 : pick;
            flags_d <= flag_vis;
            wake_q  <= wsel_q ? |(flag_vis & ~flags_d)
                              : (gie_q & |(flag_vis & en_q));
        end
    end

    assign irq_req = pick_q.valid;
    assign irq_vec = VEC_W'(vec_of(pick_q.idx));
    assign wake    = wake_q;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
    input logic clk,
    input logic rst,
    input logic irq_req,
    input logic irq_ack,
    input logic t0_evt,
    input logic t0_flag,
    input logic gie,
    input logic act_hi,
    input logic addr_hi,
    input logic rsv_bit
);

    // R4: global enable off blocks the next request
    a_r4_gie_masks: assert property (@(posedge clk) disable iff (rst)
        !gie |=> !irq_req);

    // R14: acknowledge drops the request line
    a_r14_ack_drops_req: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> !irq_req);

    // R6: nothing is presented while a high-level handler is open
    a_r6_hi_not_nested: assert property (@(posedge clk) disable iff (rst)
        act_hi |-> !irq_req);

    // R11: a timer0 event always leaves its flag set
    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        t0_evt |=> t0_flag);

    // R2: reserved bit of enable and level registers reads 1
    a_r2_reserved_one: assert property (@(posedge clk) disable iff (rst)
        !addr_hi |-> rsv_bit);

endmodule

bind irqc_top irqc_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq_req (irq_req),
    .irq_ack (irq_ack),
    .t0_evt  (src_evt[0]),
    .t0_flag (flag_vis[1]),
    .gie     (gie_q),
    .act_hi  (act_q.hi),
    .addr_hi (reg_addr[1]),
    .rsv_bit (reg_rdata[6])
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mc_tick = 1'b0;
    logic [1:0]  ext_pin = 2'b11;
    logic [3:0]  src_evt = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic        ack_mon = 1'b0, ack_man = 1'b0;
    logic        reti_mon = 1'b0, reti_man = 1'b0;
    logic        wake;
    logic        auto_on = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          exp_q[$];

    always #10 clk = ~clk;

    irqc_top u0 (
        .clk       (clk),
        .rst       (rst),
        .mc_tick   (mc_tick),
        .ext_pin   (ext_pin),
        .src_evt   (src_evt),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .irq_ack   (ack_mon | ack_man),
        .irq_reti  (reti_mon | reti_man),
        .wake      (wake)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // event pulse; returns when a resulting request is visible
    task automatic fire(input logic [3:0] m);
        src_evt = m;
        @(negedge clk);
        src_evt = '0;
        @(negedge clk);
    endtask

    task automatic tick_pins(input logic [1:0] v);
        ext_pin = v; mc_tick = 1'b1;
        @(negedge clk);
        mc_tick = 1'b0;
    endtask

    task automatic ack_m();
        ack_man = 1'b1;
        @(negedge clk);
        ack_man = 1'b0;
    endtask

    task automatic reti_m();
        reti_man = 1'b1;
        @(negedge clk);
        reti_man = 1'b0;
    endtask

    // scoreboard monitor: plays the CPU, compares vectors in order
    initial begin
        forever begin
            @(negedge clk);
            if (auto_on && irq_req) begin
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected request", int'(irq_vec), 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk("R5 R3 vector order", int'(irq_vec), e);
                end
                ack_mon = 1'b1;
                @(negedge clk);
                ack_mon = 1'b0;
                reti_mon = 1'b1;
                @(negedge clk);
                reti_mon = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 req", int'(irq_req), 0);
        chk("R1 wake", int'(wake), 0);
        rd(2'd0, d); chk("R1 enable readback", int'(d), 'h40);
        rd(2'd1, d); chk("R1 level readback", int'(d), 'h40);
        rd(2'd3, d); chk("R1 flags", int'(d), 0);

        // R2 register map
        wr(2'd0, 8'hBF);
        rd(2'd0, d); chk("R2 enable reserved bit", int'(d), 'hFF);
        wr(2'd2, 8'h03);
        rd(2'd2, d); chk("R2 control", int'(d), 'h03);

        // R5/R3 simultaneous ext0, timer0, ext1, timer1
        exp_q.push_back('h03); exp_q.push_back('h0B);
        exp_q.push_back('h13); exp_q.push_back('h1B);
        auto_on = 1'b1;
        ext_pin = 2'b00; mc_tick = 1'b1; src_evt = 4'b0011;
        @(negedge clk);
        mc_tick = 1'b0; src_evt = '0;
        wait (exp_q.size() == 0);
        repeat (4) @(negedge clk);
        auto_on = 1'b0;
        tick_pins(2'b11);
        rd(2'd3, d); chk("R10 auto clear after service", int'(d), 0);

        // R10 serial flag survives service
        fire(4'b0100);
        chk("R3 serial vector", int'(irq_vec), 'h23);
        ack_m();
        chk("R14 req low after ack", int'(irq_req), 0);
        reti_m();
        @(negedge clk);
        rd(2'd3, d); chk("R10 serial flag held", int'(d), 'h10);
        chk("R10 serial requests again", int'(irq_req), 1);
        wr(2'd3, 8'h00);
        @(negedge clk);
        chk("R10 cleared by software", int'(irq_req), 0);

        // R6 preemption
        wr(2'd1, 8'h08);
        fire(4'b0001);
        chk("R6 low vector", int'(irq_vec), 'h0B);
        ack_m();
        fire(4'b0001);
        chk("R6 same level waits", int'(irq_req), 0);
        fire(4'b0010);
        chk("R6 high preempts req", int'(irq_req), 1);
        chk("R6 high preempts vec", int'(irq_vec), 'h1B);
        ack_m();
        reti_m();
        @(negedge clk);
        chk("R6 low still open", int'(irq_req), 0);
        reti_m();
        @(negedge clk);
        chk("R6 deferred low presented", int'(irq_vec), 'h0B);
        chk("R6 deferred low req", int'(irq_req), 1);
        ack_m(); reti_m();

        // R7 bypass
        wr(2'd1, 8'h88);
        fire(4'b0011);
        chk("R7 order ignores level", int'(irq_vec), 'h0B);
        ack_m();
        @(negedge clk);
        chk("R7 no nesting", int'(irq_req), 0);
        reti_m();
        @(negedge clk);
        chk("R7 second after return", int'(irq_vec), 'h1B);
        ack_m(); reti_m();
        wr(2'd1, 8'h00);

        // R4 global enable
        wr(2'd0, 8'h3F);
        fire(4'b0001);
        chk("R4 masked", int'(irq_req), 0);
        chk("R13 no wake when masked", int'(wake), 0);
        wr(2'd0, 8'hBF);
        @(negedge clk);
        chk("R4 unmasked", int'(irq_vec), 'h0B);
        ack_m(); reti_m();

        // R9 level mode
        wr(2'd2, 8'h00);
        tick_pins(2'b10);
        rd(2'd3, d); chk("R9 level flag", int'(d), 'h01);
        @(negedge clk);
        chk("R9 ext0 vector", int'(irq_vec), 'h03);
        chk("R13 wake with enabled request", int'(wake), 1);
        ack_m();
        rd(2'd3, d); chk("R9 flag follows pin after ack", int'(d), 'h01);
        wr(2'd3, 8'h00);
        rd(2'd3, d); chk("R9 software write ignored", int'(d), 'h01);
        tick_pins(2'b11);
        rd(2'd3, d); chk("R9 pin high clears", int'(d), 0);
        reti_m();
        @(negedge clk);
        chk("R9 no request", int'(irq_req), 0);

        // R8 edge mode
        wr(2'd2, 8'h03);
        wr(2'd3, 8'h04);
        @(negedge clk);
        chk("R8 software set", int'(irq_vec), 'h13);
        ack_m();
        rd(2'd3, d); chk("R8 auto clear", int'(d), 0);
        reti_m();
        tick_pins(2'b01);
        @(negedge clk);
        chk("R8 falling edge", int'(irq_vec), 'h13);
        chk("R8 falling edge req", int'(irq_req), 1);
        ack_m(); reti_m();
        tick_pins(2'b01);
        @(negedge clk);
        rd(2'd3, d); chk("R8 held low no refire", int'(d), 0);
        chk("R8 held low no req", int'(irq_req), 0);
        tick_pins(2'b11);

        // R11 hardware set beats acknowledge clear
        fire(4'b0001);
        ack_man = 1'b1; src_evt = 4'b0001;
        @(negedge clk);
        ack_man = 1'b0; src_evt = '0;
        rd(2'd3, d); chk("R11 set beats ack", int'(d), 'h02);
        reti_m();
        @(negedge clk);
        chk("R11 presented again", int'(irq_vec), 'h0B);
        ack_m(); reti_m();
        // R11 hardware set beats software write
        reg_addr = 2'd3; reg_wdata = 8'h00; reg_wr = 1'b1; src_evt = 4'b0100;
        @(negedge clk);
        reg_wr = 1'b0; src_evt = '0;
        rd(2'd3, d); chk("R11 set beats write", int'(d), 'h10);
        wr(2'd3, 8'h00);
        @(negedge clk);

        // R12 wake on any new flag
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h07);
        fire(4'b1000);
        chk("R12 wake pulse", int'(wake), 1);
        chk("R12 no request", int'(irq_req), 0);
        @(negedge clk);
        chk("R12 pulse ends", int'(wake), 0);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h03);
        fire(4'b1000);
        chk("R13 disabled source no wake", int'(wake), 0);
        wr(2'd3, 8'h00);
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule